// File: doc/BRIEF.md
# SDRAM Low-Power Entry Controller

This block sits beside the SDRAM access engine and decides when the memory device is put into a low-power state and when it is brought back out. It watches two activity inputs from the access engine: a pending request and a transfer in progress. Once the bus has been idle for a programmable time, it requests the entry command for the selected low-power state from the command path. It drops the clock-enable pin and, for self-refresh, also gates the SDRAM clock.

When a new access arrives while the device is asleep, the block restarts the clock, then raises clock-enable and requests the exit command. It holds back the access grant for a programmable exit-to-active delay. After the access completes, the idle countdown starts again and the device goes back to sleep without any software action. Refresh scheduling and device-specific exit timing are handled elsewhere.

Top module: `sdr_lp_ctrl`

## Requirements
- R1: During and right after synchronous reset, `cke` = 1, `clk_en` = 1, `acc_ok` = 1 and `cmd_vld` = 0.
- R2: `lp_sel` encodes 0 = disabled, 1 = self-refresh, 2 = power-down, 3 = deep power-down. With 0 selected, no entry command is ever issued and `cke` stays high. An entry command is a one-cycle `cmd_vld` pulse carrying `cmd_kind` equal to the selected `lp_sel` code (1, 2 or 3).
- R3: `idle_sel` gives an idle time N: code 0 gives N = 0, code 1 gives N = 64 and code 2 gives N = 128. Counting the first clock edge with `acc_req` = 0 and `acc_busy` = 0 as edge 1, the entry command and the fall of `cke` follow edge N+1 of an unbroken idle run. Code 3 never causes entry.
- R4: Any cycle with `acc_req` or `acc_busy` high during the countdown restarts it from zero.
- R5: Self-refresh entry drives `cke` low and `clk_en` low in the same cycle.
- R6: Power-down entry drives `cke` low and keeps `clk_en` high.
- R7: Deep power-down entry (`cmd_kind` 3) happens only while `lp_mem` = 1. With `lp_mem` = 0, selecting it causes no entry.
- R8: In the low-power state, count the first edge that sees `acc_req` = 1 as edge 1. `cke` rises after edge 2, together with a one-cycle exit command (`cmd_vld` = 1, `cmd_kind` = 0). `acc_ok` rises after edge `exit_dly`+3 and stays low before that.
- R9: `clk_en` is high for at least one cycle before `cke` rises, and `acc_ok` is never high while `cke` is low.
- R10: After an access, the block re-enters the same low-power state by itself once the idle time of R3 has run out again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| lp_sel | input | 2 | Low-power state select |
| idle_sel | input | 2 | Idle time select before entry |
| lp_mem | input | 1 | Device is a low-power SDRAM (permits deep power-down) |
| exit_dly | input | EXIT_W | Extra cycles between exit command and grant |
| acc_req | input | 1 | Access engine has an access pending |
| acc_busy | input | 1 | Access engine is transferring |
| acc_ok | output | 1 | Access may proceed (device awake) |
| cke | output | 1 | SDRAM clock-enable pin |
| clk_en | output | 1 | Enable for the SDRAM clock driver |
| cmd_vld | output | 1 | One-cycle request to the command path |
| cmd_kind | output | 2 | 0 exit, 1 self-refresh, 2 power-down, 3 deep power-down entry |

## Verification
A wrong state-machine state shows up at once on `acc_ok` and `cke`. It also shows on the timing of the `cmd_vld` pulses, which the bench's scoreboard pins to an exact cycle number. A miscounting idle counter moves the entry pulse by at least one cycle at the 0, 64 and 128 boundaries, and the bench catches that within one cycle of the expected edge. A miscounting exit counter moves the rise of `acc_ok`. A gating error shows as `clk_en` low together with `cke` high, or as `clk_en` rising in the same cycle as `cke`. The bench checks both on the first cycle of every wake-up.

// File: rtl/sdr_lp_pkg.sv
package sdr_lp_pkg;

    typedef enum logic [1:0] {
        LP_OFF   = 2'd0,
        LP_SELF  = 2'd1,
        LP_PDOWN = 2'd2,
        LP_DEEP  = 2'd3
    } lp_mode_e;

    typedef enum logic [1:0] {
        ST_ON   = 2'd0,
        ST_LOW  = 2'd1,
        ST_WCLK = 2'd2,
        ST_WAIT = 2'd3
    } lp_state_e;

    localparam logic [1:0] CMD_EXIT = 2'd0;
    localparam logic [1:0] IDLE_NEVER = 2'd3;

    typedef struct packed {
        logic       vld;
        logic [1:0] kind;
    } lp_cmd_t;

    typedef struct packed {
        logic cke;
        logic clk_en;
    } pad_ctl_t;

    function automatic int unsigned idle_limit(logic [1:0] code,
                                               int unsigned short_n,
                                               int unsigned long_n);
        case (code)
            2'd1:    return short_n;
            2'd2:    return long_n;
            default: return 0;
        endcase
    endfunction

    function automatic logic entry_allowed(lp_mode_e m, logic lp_mem);
        return (m != LP_OFF) && ((m != LP_DEEP) || lp_mem);
    endfunction

endpackage

// File: rtl/sdr_lp_idle.sv
module sdr_lp_idle
    import sdr_lp_pkg::*;
#(
    parameter int unsigned SHORT_IDLE = 64,
    parameter int unsigned LONG_IDLE  = 128
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic [1:0] idle_sel,
    output logic       hit
);
    localparam int CW = $clog2(LONG_IDLE + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;

    assign lim = CW'(idle_limit(idle_sel, SHORT_IDLE, LONG_IDLE));
    assign hit = !clr && (idle_sel != IDLE_NEVER) && (cnt >= lim);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (cnt < lim) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R4: a restart empties the countdown for the following cycle
    a_r4_restart: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt == '0));

endmodule

// File: rtl/sdr_lp_wake.sv
module sdr_lp_wake #(
    parameter int EXIT_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [EXIT_W-1:0] dly,
    output logic              done
);
    logic [EXIT_W-1:0] cnt;

    assign done = (cnt >= dly);

    always_ff @(posedge clk) begin
        if (rst || start) begin
            cnt <= '0;
        end else if (cnt < dly) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/sdr_lp_ctrl.sv
module sdr_lp_ctrl
    import sdr_lp_pkg::*;
#(
    parameter int unsigned SHORT_IDLE = 64,
    parameter int unsigned LONG_IDLE  = 128,
    parameter int          EXIT_W     = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        lp_sel,
    input  logic [1:0]        idle_sel,
    input  logic              lp_mem,
    input  logic [EXIT_W-1:0] exit_dly,
    input  logic              acc_req,
    input  logic              acc_busy,
    output logic              acc_ok,
    output logic              cke,
    output logic              clk_en,
    output logic              cmd_vld,
    output logic [1:0]        cmd_kind
);
    lp_state_e st;
    lp_cmd_t   cmd;
    pad_ctl_t  pad;
    lp_mode_e  mode;
    logic      idle_clr;
    logic      idle_hit;
    logic      wake_done;

    assign mode     = lp_mode_e'(lp_sel);
    assign idle_clr = (st != ST_ON) || acc_req || acc_busy;

    sdr_lp_idle #(
        .SHORT_IDLE(SHORT_IDLE),
        .LONG_IDLE (LONG_IDLE)
    ) u_idle (
        .clk     (clk),
        .rst     (rst),
        .clr     (idle_clr),
        .idle_sel(idle_sel),
        .hit     (idle_hit)
    );

    sdr_lp_wake #(
        .EXIT_W(EXIT_W)
    ) u_wake (
        .clk  (clk),
        .rst  (rst),
        .start(st == ST_WCLK),
        .dly  (exit_dly),
        .done (wake_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= ST_ON;
            cmd <= '{vld: 1'b0, kind: CMD_EXIT};
            pad <= '{cke: 1'b1, clk_en: 1'b1};
        end else begin
            cmd.vld <= 1'b0;
            case (st)
                ST_ON: begin
                    if (idle_hit && entry_allowed(mode, lp_mem)) begin
                        st         <= ST_LOW;
                        cmd        <= '{vld: 1'b1, kind: lp_sel};
                        pad.cke    <= 1'b0;
                        pad.clk_en <= (mode != LP_SELF);
                    end
                end
                ST_LOW: begin
                    if (acc_req) begin
                        st         <= ST_WCLK;
                        pad.clk_en <= 1'b1;
                    end
                end
                ST_WCLK: begin
                    st      <= ST_WAIT;
                    pad.cke <= 1'b1;
                    cmd     <= '{vld: 1'b1, kind: CMD_EXIT};
                end
                default: begin
                    if (wake_done) begin
                        st <= ST_ON;
                    end
                end
            endcase
        end
    end

    assign acc_ok   = (st == ST_ON);
    assign cke      = pad.cke;
    assign clk_en   = pad.clk_en;
    assign cmd_vld  = cmd.vld;
    assign cmd_kind = cmd.kind;

    // R9: clock runs during the cycle before clock-enable rises
    a_r9_clk_first: assert property (@(posedge clk) disable iff (rst)
        $rose(cke) |-> $past(clk_en));

    // R9: no grant while the device is asleep
    a_r9_no_grant_asleep: assert property (@(posedge clk) disable iff (rst)
        acc_ok |-> cke);

    // R5: clock is only stopped while clock-enable is low
    a_r5_clk_stop_cke_low: assert property (@(posedge clk) disable iff (rst)
        !clk_en |-> !cke);

    // R2: every fall of clock-enable comes with an entry command
    a_r2_fall_has_cmd: assert property (@(posedge clk) disable iff (rst)
        $fell(cke) |-> (cmd_vld && (cmd_kind != CMD_EXIT)));

    // R8: every rise of clock-enable comes with an exit command
    a_r8_rise_has_exit: assert property (@(posedge clk) disable iff (rst)
        $rose(cke) |-> (cmd_vld && (cmd_kind == CMD_EXIT)));

    // R7: deep power-down only for a low-power device
    a_r7_deep_needs_mem: assert property (@(posedge clk) disable iff (rst)
        (cmd_vld && (cmd_kind == 2'd3)) |-> $past(lp_mem));

endmodule

// File: tb/sim_sdr_lp_ctrl.sv
module sim_sdr_lp_ctrl;

    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] lp_sel;
    logic [1:0] idle_sel;
    logic       lp_mem;
    logic [3:0] exit_dly;
    logic       acc_req;
    logic       acc_busy;
    logic       acc_ok;
    logic       cke;
    logic       clk_en;
    logic       cmd_vld;
    logic [1:0] cmd_kind;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    int exp_cyc[$];
    int exp_kind[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sdr_lp_ctrl u0 (
        .clk     (clk),
        .rst     (rst),
        .lp_sel  (lp_sel),
        .idle_sel(idle_sel),
        .lp_mem  (lp_mem),
        .exit_dly(exit_dly),
        .acc_req (acc_req),
        .acc_busy(acc_busy),
        .acc_ok  (acc_ok),
        .cke     (cke),
        .clk_en  (clk_en),
        .cmd_vld (cmd_vld),
        .cmd_kind(cmd_kind)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: act=%0d exp=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // scoreboard monitor: every command pulse must match the next expected item
    always @(negedge clk) begin
        if (!rst && cmd_vld) begin
            checks++;
            if (exp_cyc.size() == 0) begin
                errors++;
                $display("FAIL R2 unexpected command: act=%0d exp=none (cycle %0d)", cmd_kind, cyc);
            end else begin
                int ec;
                int ek;
                ec = exp_cyc.pop_front();
                ek = exp_kind.pop_front();
                if (ec != cyc || ek != int'(cmd_kind)) begin
                    errors++;
                    $display("FAIL R3/R8 command: act=kind %0d @%0d exp=kind %0d @%0d",
                             cmd_kind, cyc, ek, ec);
                end
            end
        end
    end

    task automatic busy(input int n);
        acc_req  = 1'b0;
        acc_busy = 1'b1;
        repeat (n) @(negedge clk);
    endtask

    task automatic idle_expect(input int kind, input int n);
        acc_req  = 1'b0;
        acc_busy = 1'b0;
        exp_cyc.push_back(cyc + 1 + n);
        exp_kind.push_back(kind);
        repeat (n) @(negedge clk);
        chk("R3 cke before timeout", cke, 1);
        @(negedge clk);
        chk("R3 cke after timeout", cke, 0);
        chk((kind == 1) ? "R5 clk_en self-refresh" : "R6 clk_en kept", clk_en, (kind == 1) ? 0 : 1);
        chk("R9 acc_ok asleep", acc_ok, 0);
    endtask

    task automatic wake(input int d);
        exit_dly = 4'(d);
        acc_req  = 1'b1;
        acc_busy = 1'b0;
        exp_cyc.push_back(cyc + 2);
        exp_kind.push_back(0);
        @(negedge clk);
        chk("R9 clk restarted first", clk_en, 1);
        chk("R9 cke still low", cke, 0);
        @(negedge clk);
        chk("R8 cke raised", cke, 1);
        chk("R8 grant held", acc_ok, 0);
        repeat (d) @(negedge clk);
        chk("R8 grant held at delay end", acc_ok, 0);
        @(negedge clk);
        chk("R8 grant given", acc_ok, 1);
    endtask

    task automatic run_tests;
        rst = 1'b1; lp_sel = 2'd0; idle_sel = 2'd0; lp_mem = 1'b0;
        exit_dly = 4'd0; acc_req = 1'b0; acc_busy = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 reset cke", cke, 1);
        chk("R1 reset clk_en", clk_en, 1);
        chk("R1 reset acc_ok", acc_ok, 1);
        chk("R1 reset cmd_vld", cmd_vld, 0);
        rst = 1'b0;

        // R2: disabled mode never enters
        repeat (20) @(negedge clk);
        chk("R2 disabled cke", cke, 1);
        chk("R2 disabled acc_ok", acc_ok, 1);

        // R6 power-down, immediate entry, then R10 return after access
        lp_sel = 2'd2;
        busy(2);
        idle_expect(2, 0);
        repeat (5) @(negedge clk);
        chk("R6 stays asleep", cke, 0);
        wake(3);
        busy(3);
        idle_expect(2, 0);
        chk("R10 back in power-down", cke, 0);

        // R4 restart and R5 self-refresh after 64 idle cycles
        wake(0);
        lp_sel = 2'd1; idle_sel = 2'd1;
        busy(2);
        acc_busy = 1'b0;
        repeat (40) @(negedge clk);
        busy(1);
        chk("R4 no entry before restart ends", cke, 1);
        idle_expect(1, 64);
        wake(5);

        // R3 long timeout
        idle_sel = 2'd2;
        busy(2);
        idle_expect(1, 128);
        wake(15);

        // R3 reserved code never enters
        idle_sel = 2'd3;
        busy(1);
        acc_busy = 1'b0;
        repeat (300) @(negedge clk);
        chk("R3 reserved code", cke, 1);

        // R7 deep power-down gated by device type
        idle_sel = 2'd0; lp_sel = 2'd3; lp_mem = 1'b0;
        busy(1);
        acc_busy = 1'b0;
        repeat (10) @(negedge clk);
        chk("R7 deep blocked", cke, 1);
        lp_mem = 1'b1;
        idle_expect(3, 0);
        wake(2);
        lp_sel = 2'd0;
        busy(1);
        acc_busy = 1'b0;
        repeat (5) @(negedge clk);
        chk("R2 no pending commands", exp_cyc.size(), 0);
    endtask

    initial begin
        fork
            run_tests();
            begin
                repeat (20000) @(posedge clk);
                errors++;
                $display("FAIL watchdog: act=timeout exp=done");
            end
        join_any
        disable fork;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule